// File: doc/BRIEF.md
# Double-Buffered Audio DMA Player

This block plays audio from memory. Software stores a buffer of 32-bit stereo words in memory, writes the buffer's start address and then its byte length into a small register window, and the block streams that buffer out one word per sample period. Each word holds one left and one right 16-bit sample. The block passes the samples through unchanged and converts nothing.

The block keeps two transfer slots. One is playing and one is waiting, so software can queue the next buffer while the current one still sounds. When the playing buffer runs out, the waiting one takes over on the next sample period with no gap. The interrupt request pulses when a buffer enters the playing slot, not when it ends. This gives software a full buffer's worth of time to prepare the next one.

A pacing counter sets the sample rate. It reloads from a programmable divider, so the time between output samples is the divider value plus one clock. Memory is read over a simple request/response port with at most one word in flight. One word is prefetched ahead of the strobe that consumes it.

Top module: `audio_dma_player`

## Requirements
- R1: After reset, every register offset (0x0, 0x4, 0x8, 0xC) reads zero, and `irq`, `sample_valid`, `sample_left` and `sample_right` are zero.
- R2: The address register at offset 0x0 keeps only bits 23:0 of the written value, and that value is the first memory address fetched. A read at offset 0x0 returns the length register.
- R3: A write to offset 0x4 stores the value with bits 2:0 forced to zero. If the stored length is non-zero, a transfer is queued. A length of zero queues nothing and leaves the block idle.
- R4: Each memory word reaches the output unchanged: bits 31:16 appear on `sample_left` and bits 15:0 on `sample_right`. Words are fetched from consecutive addresses, starting at the buffer address and stepping by 4.
- R5: The divider at offset 0x8 reads back as written. While playing, consecutive `sample_valid` pulses are exactly divider+1 clocks apart, for divider values of 8 or more.
- R6: `irq` is a single-cycle pulse, raised once each time a buffer enters the playing slot. This happens both when a transfer starts from idle and when a queued one takes over. The pulse comes before that buffer's first sample.
- R7: When a buffer is waiting, the gap from the last sample of the playing buffer to the first sample of the next one is the same divider+1 clocks as inside a buffer.
- R8: The status register at offset 0xC reports busy in bit 0 (a buffer is playing) and full in bit 1 (both slots are occupied). A length write while full is ignored: the length register keeps its value and no extra transfer plays.
- R9: When the last buffer ends with nothing waiting, busy falls, no further memory requests are made, no further samples are produced, and the outputs hold the last sample.
- R10: A buffer of L bytes produces exactly L/4 memory requests and L/4 samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | BUS_W (32) | Register write data |
| reg_rdata | output | BUS_W (32) | Register read data for `reg_addr` |
| mem_req | output | 1 | One-cycle memory read request |
| mem_addr | output | ADDR_W (24) | Byte address of the requested word |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 2*SAMPLE_W (32) | Read data word |
| sample_left | output | SAMPLE_W (16) | Left sample, held between strobes |
| sample_right | output | SAMPLE_W (16) | Right sample, held between strobes |
| sample_valid | output | 1 | Pulses when a new stereo pair is presented |
| irq | output | 1 | Pulses when a buffer starts playing |

## Verification
The bench builds the block with its default parameters: 24-bit addresses, 18-bit lengths, a 16-bit divider and 16-bit samples. It attaches a memory model that answers two cycles after each request. Dividers of 9 and 11 keep the runs short while still leaving room for the refetch after a buffer switch, so the gap-free handover and the interrupt timing are both measured. Buffers of two and four words let the bench fill both slots, try a third write against a full queue, and watch the block stop and hold its last sample, all within a few hundred cycles.

// File: rtl/adp_pkg.sv
package adp_pkg;
  // Register byte offsets inside the window
  localparam logic [3:0] OFF_ADDR = 4'h0;
  localparam logic [3:0] OFF_LEN  = 4'h4;
  localparam logic [3:0] OFF_DIV  = 4'h8;
  localparam logic [3:0] OFF_STAT = 4'hC;
  // Status bit positions
  localparam int STAT_BUSY = 0;
  localparam int STAT_FULL = 1;
  // Bytes per stereo word
  localparam int WORD_BYTES = 4;
endpackage

// File: rtl/adp_regs.sv
module adp_regs
  import adp_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int LEN_W  = 18,
  parameter int DIV_W  = 16,
  parameter int BUS_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [3:0]        addr,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  rdata,
  input  logic              busy,
  input  logic              full,
  output logic              push,
  output logic [ADDR_W-1:0] push_addr,
  output logic [LEN_W-1:0]  push_len,
  output logic [DIV_W-1:0]  div
);
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [LEN_W-1:0]  len_q, len_d, len_masked;
  logic [DIV_W-1:0]  div_q, div_d;
  logic              len_wr;

  assign len_masked = {wdata[LEN_W-1:3], 3'b000};

  always_comb begin
    addr_d = addr_q;
    len_d  = len_q;
    div_d  = div_q;
    len_wr = wr_en && (addr == OFF_LEN) && !full;
    if (wr_en && addr == OFF_ADDR) addr_d = wdata[ADDR_W-1:0];
    if (wr_en && addr == OFF_DIV)  div_d  = wdata[DIV_W-1:0];
    if (len_wr)                    len_d  = len_masked;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      len_q  <= '0;
      div_q  <= '0;
    end else begin
      addr_q <= addr_d;
      len_q  <= len_d;
      div_q  <= div_d;
    end
  end

  assign push      = len_wr && (len_masked != '0);
  assign push_addr = addr_q;
  assign push_len  = len_masked;
  assign div       = div_q;

  always_comb begin
    rdata = '0;
    case (addr)
      OFF_ADDR, OFF_LEN: rdata = BUS_W'(len_q);
      OFF_DIV:           rdata = BUS_W'(div_q);
      OFF_STAT: begin
        rdata[STAT_BUSY] = busy;
        rdata[STAT_FULL] = full;
      end
      default:           rdata = '0;
    endcase
  end
endmodule

// File: rtl/adp_queue.sv
module adp_queue #(
  parameter int ADDR_W = 24,
  parameter int LEN_W  = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [LEN_W-1:0]  push_len,
  input  logic              pop,
  output logic              busy,
  output logic              full,
  output logic              start,
  output logic [ADDR_W-1:0] head_addr,
  output logic [LEN_W-1:0]  head_len
);
  logic              hv_q, hv_d, tv_q, tv_d, start_q, start_d;
  logic [ADDR_W-1:0] ha_q, ha_d, ta_q, ta_d;
  logic [LEN_W-1:0]  hl_q, hl_d, tl_q, tl_d;

  always_comb begin
    hv_d = hv_q; tv_d = tv_q;
    ha_d = ha_q; hl_d = hl_q;
    ta_d = ta_q; tl_d = tl_q;
    start_d = 1'b0;
    // playing buffer finished: waiting one moves up
    if (pop) begin
      if (tv_q) begin
        ha_d = ta_q; hl_d = tl_q;
        tv_d = 1'b0; start_d = 1'b1;
      end else begin
        hv_d = 1'b0;
      end
    end
    // new transfer (the register file already refuses it when full)
    if (push) begin
      if (!hv_d) begin
        ha_d = push_addr; hl_d = push_len;
        hv_d = 1'b1; start_d = 1'b1;
      end else if (!tv_d) begin
        ta_d = push_addr; tl_d = push_len;
        tv_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hv_q <= 1'b0; tv_q <= 1'b0; start_q <= 1'b0;
      ha_q <= '0; hl_q <= '0; ta_q <= '0; tl_q <= '0;
    end else begin
      hv_q <= hv_d; tv_q <= tv_d; start_q <= start_d;
      ha_q <= ha_d; hl_q <= hl_d; ta_q <= ta_d; tl_q <= tl_d;
    end
  end

  assign busy      = hv_q;
  assign full      = hv_q && tv_q;
  assign start     = start_q;
  assign head_addr = ha_q;
  assign head_len  = hl_q;
endmodule

// File: rtl/adp_pacer.sv
module adp_pacer #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             strobe
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    strobe = 1'b0;
    if (!run) begin
      cnt_d = div;
    end else if (cnt_q == '0) begin
      cnt_d  = div;
      strobe = 1'b1;
    end else begin
      cnt_d = cnt_q - DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/adp_stream.sv
module adp_stream
  import adp_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int LEN_W  = 18,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  start_len,
  input  logic              strobe,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [WORD_W-1:0] word,
  output logic              word_valid,
  output logic              done
);
  localparam int WCNT_W = LEN_W - 2;

  logic [ADDR_W-1:0] fa_q, fa_d;
  logic [WCNT_W-1:0] fl_q, fl_d, pl_q, pl_d;
  logic              out_q, out_d, bv_q, bv_d, wv_q, wv_d, dn_q, dn_d;
  logic [WORD_W-1:0] buf_q, buf_d, w_q, w_d;
  logic              consume;

  assign mem_req = (fl_q != '0) && !out_q && !bv_q;
  assign consume = strobe && bv_q;

  always_comb begin
    fa_d = fa_q; fl_d = fl_q; pl_d = pl_q;
    out_d = out_q; bv_d = bv_q; buf_d = buf_q; w_d = w_q;
    wv_d = 1'b0; dn_d = 1'b0;
    if (start) begin
      fa_d = start_addr;
      fl_d = start_len[LEN_W-1:2];
      pl_d = start_len[LEN_W-1:2];
    end else if (mem_req) begin
      fa_d  = fa_q + ADDR_W'(WORD_BYTES);
      fl_d  = fl_q - WCNT_W'(1);
      out_d = 1'b1;
    end
    if (mem_rvalid) begin
      out_d = 1'b0;
      bv_d  = 1'b1;
      buf_d = mem_rdata;
    end
    if (consume) begin
      bv_d = 1'b0;
      w_d  = buf_q;
      wv_d = 1'b1;
      pl_d = pl_q - WCNT_W'(1);
      dn_d = (pl_q == WCNT_W'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fa_q <= '0; fl_q <= '0; pl_q <= '0;
      out_q <= 1'b0; bv_q <= 1'b0; wv_q <= 1'b0; dn_q <= 1'b0;
      buf_q <= '0; w_q <= '0;
    end else begin
      fa_q <= fa_d; fl_q <= fl_d; pl_q <= pl_d;
      out_q <= out_d; bv_q <= bv_d; wv_q <= wv_d; dn_q <= dn_d;
      buf_q <= buf_d;
      if (consume) w_q <= w_d;
    end
  end

  assign mem_addr   = fa_q;
  assign word       = w_q;
  assign word_valid = wv_q;
  assign done       = dn_q;
endmodule

// File: rtl/audio_dma_player.sv
module audio_dma_player #(
  parameter int ADDR_W   = 24,
  parameter int LEN_W    = 18,
  parameter int DIV_W    = 16,
  parameter int SAMPLE_W = 16,
  parameter int BUS_W    = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr_en,
  input  logic [3:0]            reg_addr,
  input  logic [BUS_W-1:0]      reg_wdata,
  output logic [BUS_W-1:0]      reg_rdata,
  output logic                  mem_req,
  output logic [ADDR_W-1:0]     mem_addr,
  input  logic                  mem_rvalid,
  input  logic [2*SAMPLE_W-1:0] mem_rdata,
  output logic [SAMPLE_W-1:0]   sample_left,
  output logic [SAMPLE_W-1:0]   sample_right,
  output logic                  sample_valid,
  output logic                  irq
);
  localparam int WORD_W = 2 * SAMPLE_W;
  localparam int NCH    = 2;

  logic [1:0]        rs_q;
  logic              rst_core_n;
  logic              q_busy, q_full, q_start, push, pop, strobe;
  logic [ADDR_W-1:0] push_addr, head_addr;
  logic [LEN_W-1:0]  push_len, head_len;
  logic [DIV_W-1:0]  div;
  logic [WORD_W-1:0] word;
  logic [SAMPLE_W-1:0] ch [NCH];

  // reset asserts at once, releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_core_n = rs_q[1];

  adp_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DIV_W(DIV_W), .BUS_W(BUS_W)) regs_i (
    .clk(clk), .rst_n(rst_core_n), .wr_en(reg_wr_en), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .busy(q_busy), .full(q_full),
    .push(push), .push_addr(push_addr), .push_len(push_len), .div(div));

  adp_queue #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) queue_i (
    .clk(clk), .rst_n(rst_core_n), .push(push), .push_addr(push_addr),
    .push_len(push_len), .pop(pop), .busy(q_busy), .full(q_full),
    .start(q_start), .head_addr(head_addr), .head_len(head_len));

  adp_pacer #(.DIV_W(DIV_W)) pacer_i (
    .clk(clk), .rst_n(rst_core_n), .run(q_busy), .div(div), .strobe(strobe));

  adp_stream #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .WORD_W(WORD_W)) stream_i (
    .clk(clk), .rst_n(rst_core_n), .start(q_start), .start_addr(head_addr),
    .start_len(head_len), .strobe(strobe), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .word(word), .word_valid(sample_valid), .done(pop));

  // channel k takes the k-th sample slice of the word, right in the low half
  for (genvar k = 0; k < NCH; k++) begin : g_ch
    assign ch[k] = word[k*SAMPLE_W +: SAMPLE_W];
  end

  assign sample_right = ch[0];
  assign sample_left  = ch[1];
  assign irq          = q_start;
endmodule

// File: rtl/adp_checker.sv
module adp_checker (
  input logic clk,
  input logic rst_n,
  input logic irq,
  input logic busy,
  input logic full,
  input logic mem_req,
  input logic sample_valid
);
  a_r6_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  a_r6_irq_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> busy);
  a_r8_full_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> busy);
  a_r9_idle_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);
  a_r5_samples_spaced: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |=> !sample_valid);
  a_r10_single_request: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
endmodule

bind audio_dma_player adp_checker chk_i (
  .clk(clk), .rst_n(rst_n), .irq(irq), .busy(q_busy), .full(q_full),
  .mem_req(mem_req), .sample_valid(sample_valid));

// File: tb/audio_dma_player_tb_top.sv
`timescale 1ns/1ps
module audio_dma_player_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [3:0]  reg_addr = 4'h0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req;
  logic [23:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic [15:0] sample_left, sample_right;
  logic        sample_valid, irq;

  audio_dma_player dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .sample_left(sample_left), .sample_right(sample_right),
    .sample_valid(sample_valid), .irq(irq));

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int n_s = 0, n_irq = 0, n_req = 0;
  int s_cyc [32];
  logic [15:0] s_l [32];
  logic [15:0] s_r [32];
  int irq_cyc [8];
  logic [23:0] req_addr [32];

  function automatic logic [31:0] mdata(input logic [23:0] a);
    return {a[15:0] ^ 16'hC3A5, ~a[15:0]};
  endfunction

  // memory model: answers two cycles after a request
  logic        p1 = 1'b0;
  logic [23:0] a1 = '0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    p1 <= mem_req;
    a1 <= mem_addr;
    mem_rvalid <= p1;
    mem_rdata <= mdata(a1);
  end

  // observer, away from the active edge
  always @(negedge clk) begin
    if (sample_valid && n_s < 32) begin
      s_cyc[n_s] = cyc; s_l[n_s] = sample_left; s_r[n_s] = sample_right;
      n_s++;
    end
    if (irq && n_irq < 8) begin
      irq_cyc[n_irq] = cyc; n_irq++;
    end
    if (mem_req && n_req < 32) begin
      req_addr[n_req] = mem_addr; n_req++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic clear_log();
    n_s = 0; n_irq = 0; n_req = 0;
  endtask

  task automatic wait_idle();
    logic [31:0] st;
    for (int i = 0; i < 3000; i++) begin
      rd(4'hC, st);
      if (st[0] == 1'b0) break;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(4'h0, v); chk("R1 addr offset", v, 0);
    rd(4'h4, v); chk("R1 length", v, 0);
    rd(4'h8, v); chk("R1 divider", v, 0);
    rd(4'hC, v); chk("R1 status", v, 0);
    chk("R1 outputs", {sample_left, sample_right}, 0);
    chk("R1 irq/valid", {30'd0, irq, sample_valid}, 0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    clear_log();
    wr(4'h8, 32'd9);
    rd(4'h8, v); chk("R5 divider readback", v, 9);
    wr(4'h0, 32'h0000_0400);
    wr(4'h4, 32'h0000_0007);          // masks to zero
    rd(4'h4, v); chk("R3 zero length stored", v, 0);
    repeat (20) @(negedge clk);
    rd(4'hC, v); chk("R3 zero length stays idle", v, 0);
    chk("R3 zero length no irq", n_irq, 0);
    chk("R3 zero length no fetch", n_req, 0);
  endtask

  task automatic t_single();
    logic [31:0] v, w;
    clear_log();
    wr(4'h0, 32'hFF00_0100);          // upper byte dropped
    wr(4'h4, 32'h0000_0013);          // 4 words after masking
    rd(4'h4, v); chk("R3 length masked", v, 32'h10);
    rd(4'h0, v); chk("R2 address offset reads length", v, 32'h10);
    wait_idle();
    chk("R10 sample count", n_s, 4);
    chk("R10 request count", n_req, 4);
    chk("R2 first fetch address", req_addr[0], 24'h000100);
    for (int k = 0; k < 4; k++) begin
      w = mdata(24'h000100 + 24'(4*k));
      chk("R4 left sample", s_l[k], w[31:16]);
      chk("R4 right sample", s_r[k], w[15:0]);
      chk("R4 fetch address", req_addr[k], 24'h000100 + 24'(4*k));
      if (k > 0) chk("R5 sample spacing", s_cyc[k] - s_cyc[k-1], 10);
    end
    chk("R6 one irq", n_irq, 1);
    chk("R6 irq before first sample", irq_cyc[0] < s_cyc[0], 1);
    w = mdata(24'h00010C);
    rd(4'hC, v); chk("R9 busy cleared", v, 0);
    repeat (40) @(negedge clk);
    chk("R9 output holds", {sample_left, sample_right}, w);
    chk("R9 no further samples", n_s, 4);
    chk("R9 no further fetch", n_req, 4);
  endtask

  task automatic t_double();
    logic [31:0] v, w;
    clear_log();
    wr(4'h8, 32'd11);
    wr(4'h0, 32'h0000_2000);
    wr(4'h4, 32'd16);
    wr(4'h0, 32'h0000_3000);
    wr(4'h4, 32'd8);
    rd(4'hC, v); chk("R8 busy and full", v, 3);
    wr(4'h0, 32'h0000_5000);
    wr(4'h4, 32'd24);                 // refused: queue full
    rd(4'h4, v); chk("R8 length kept when full", v, 8);
    wait_idle();
    chk("R8 third buffer not played", n_s, 6);
    chk("R10 request count two buffers", n_req, 6);
    for (int k = 0; k < 6; k++) begin
      w = (k < 4) ? mdata(24'h002000 + 24'(4*k)) : mdata(24'h003000 + 24'(4*(k-4)));
      chk("R4 stereo word", {s_l[k], s_r[k]}, w);
      if (k > 0 && k != 4) chk("R5 spacing", s_cyc[k] - s_cyc[k-1], 12);
    end
    chk("R7 handover gap", s_cyc[4] - s_cyc[3], 12);
    chk("R6 two irqs", n_irq, 2);
    chk("R6 second irq after first buffer", irq_cyc[1] > s_cyc[3], 1);
    chk("R6 second irq before its first sample", irq_cyc[1] < s_cyc[4], 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_regs();
    t_single();
    t_double();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=finish", cyc);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule